// File: doc/BRIEF.md
# Synchronous Character Receiver with Sync Hunt

This block receives a character-oriented synchronous serial line. A one-cycle bit strobe marks each received bit. The serial input comes from the line pin, or from the local transmitter when loopback is selected. After the receiver is enabled, it searches the bit stream for a sync pattern that software loads. The search is done one bit at a time. Once the pattern is found, the receiver frames every following group of bits as a character. The character length is programmable from 5 to 8 bits.

Each completed character goes into a single holding register, so one character can wait while the next one is shifted in. Software reads the holding register with a read strobe. The block reports data-ready, overrun, sync-detect and receive-active status, and raises an interrupt request while data is waiting and interrupts are enabled. As an option, framed characters that equal the sync pattern are dropped instead of delivered.

The control state machine has three states:
- OFF: the receiver is disabled.
- HUNT: the receiver is searching for the sync pattern.
- ASSEMBLE: the receiver is framing characters.

It has four transitions:
- *enable*: OFF to HUNT when `rx_enable` rises.
- *lock*: HUNT to ASSEMBLE when a strobed bit completes a sync match.
- *stay*: ASSEMBLE to ASSEMBLE while the receiver is enabled.
- *disable*: any state to OFF when `rx_enable` is low.

Top module: `sync_char_rx`

## Requirements
- R1: The character length is `len_sel + 5` bits (`len_sel` 0..3 gives 5..8). `rx_char` holds the character right-justified, and any bits above the length read as zero.
- R2: The first bit received in a character becomes bit 0 of `rx_char`. Later bits fill the higher positions in order.
- R3: In HUNT, after each strobed bit, the receiver compares the most recent `len` bits with the low `len` bits of `sync_char`. On a match it moves to ASSEMBLE, and the next `len` bits form the first character. Nothing is delivered while in HUNT.
- R4: `sync_det` is set when a HUNT match occurs. It is also set when a framed character equals the sync pattern. It stays set until a read strobe clears it.
- R5: When `strip_sync` is 1, a framed character equal to the sync pattern is dropped. When `strip_sync` is 0, such a character is delivered like any other data.
- R6: `rx_active` goes to 1 on the cycle after the first character is delivered following enable. It does not go to 1 earlier.
- R7: A delivered character sets `data_ready` and stays in `rx_char` until the next delivery. A read strobe clears `data_ready`.
- R8: If a character is delivered while `data_ready` is already 1 and no read strobe is present, `overrun` is set and `rx_char` takes the newer character. A read strobe clears `overrun`.
- R9: `rx_irq` equals `data_ready` AND `irq_en`.
- R10: When `loop_sel` is 1, bits come from `loop_tx` and `line_rx` is ignored. When `loop_sel` is 0, the reverse holds.
- R11: When `rx_enable` is 0, the block goes to OFF, clears `rx_active` and the bit window, and delivers nothing. The holding register keeps its contents.
- R12: The serial input is sampled only on cycles where `bit_en` is 1. Changes in the input at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Receive bit strobe, one cycle per bit |
| line_rx | input | 1 | Serial data from the line |
| loop_tx | input | 1 | Serial data from the local transmitter |
| loop_sel | input | 1 | 1 selects `loop_tx` as the receive input |
| rx_enable | input | 1 | Receiver enable |
| strip_sync | input | 1 | Drop framed characters equal to the sync pattern |
| len_sel | input | 2 | Character length minus 5 |
| sync_char | input | 8 | Sync pattern; its low `len` bits are used |
| irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Read of the holding register |
| rx_char | output | 8 | Holding register, right-justified |
| data_ready | output | 1 | A character is waiting |
| overrun | output | 1 | A character was overwritten before it was read |
| rx_active | output | 1 | At least one character delivered since enable |
| sync_det | output | 1 | Sync pattern seen since the last read |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench sweeps all four lengths, three sync patterns, both strip settings and both input sources. Each run starts with a pseudo-random preamble, so a false lock inside the noise can occur and must be followed exactly. Two back-to-back sync characters then separate the strip and deliver behaviours. After them come data characters whose values are computed per case, which shows whether the bit order and the justification are correct. In each run, one character is left unread to provoke an overrun, and the input is toggled between strobes to show that only strobed bits are taken. A disabled period then follows in which a sync and a data character are sent and must be ignored.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_HUNT,
        ST_ASSEM
    } rx_state_t;
endpackage

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         bit_en,
    input  logic         line_in,
    input  logic         loop_in,
    input  logic         loop_sel,
    output logic [W-1:0] win_nxt
);
    logic [W-1:0] sh;
    logic         din;

    always_comb begin
        din     = loop_sel ? loop_in : line_in;
        win_nxt = bit_en ? {din, sh[W-1:1]} : sh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) sh <= '0;
        else               sh <= win_nxt;
    end
endmodule

// File: rtl/sync_rx_fsm.sv
module sync_rx_fsm
    import sync_rx_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_enable,
    input  logic          bit_en,
    input  logic          match,
    input  logic          strip,
    input  logic [CW-1:0] last_idx,
    output logic          deliver,
    output logic          sync_seen,
    output logic          rx_active
);
    rx_state_t     state, state_nxt;
    logic [CW-1:0] cnt;
    logic          last;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:   if (rx_enable) state_nxt = ST_HUNT;
            ST_HUNT:  if (!rx_enable) state_nxt = ST_OFF;
                      else if (bit_en && match) state_nxt = ST_ASSEM;
            ST_ASSEM: if (!rx_enable) state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        last      = (cnt == last_idx);
        deliver   = rx_enable && bit_en && (state == ST_ASSEM) && last
                    && !(strip && match);
        sync_seen = rx_enable && bit_en && match
                    && ((state == ST_HUNT) || ((state == ST_ASSEM) && last));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            rx_active <= 1'b0;
        end else if (!rx_enable) begin
            cnt       <= '0;
            rx_active <= 1'b0;
        end else begin
            if (state != ST_ASSEM) cnt <= '0;
            else if (bit_en)       cnt <= last ? '0 : cnt + 1'b1;
            if (deliver) rx_active <= 1'b1;
        end
    end

    AST_ACT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (!rx_active && state == ST_OFF)); // R11
    AST_ACT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_active) |-> $past(deliver)); // R6
endmodule

// File: rtl/sync_rx_hold.sv
module sync_rx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         deliver,
    input  logic         sync_seen,
    input  logic         rd,
    input  logic [W-1:0] new_char,
    output logic [W-1:0] rx_char,
    output logic         data_ready,
    output logic         overrun,
    output logic         sync_det
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_char    <= '0;
            data_ready <= 1'b0;
            overrun    <= 1'b0;
            sync_det   <= 1'b0;
        end else begin
            if (deliver) rx_char <= new_char;

            if (deliver)  data_ready <= 1'b1;
            else if (rd)  data_ready <= 1'b0;

            if (deliver && data_ready && !rd) overrun <= 1'b1;
            else if (rd)                      overrun <= 1'b0;

            if (sync_seen) sync_det <= 1'b1;
            else if (rd)   sync_det <= 1'b0;
        end
    end

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver && data_ready && !rd) |=> overrun); // R8
    AST_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !deliver) |=> !data_ready); // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !deliver |=> $stable(rx_char)); // R7
endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx #(
    parameter int W       = 8,
    parameter int MIN_LEN = 5,
    parameter int LSW     = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_en,
    input  logic           line_rx,
    input  logic           loop_tx,
    input  logic           loop_sel,
    input  logic           rx_enable,
    input  logic           strip_sync,
    input  logic [LSW-1:0] len_sel,
    input  logic [W-1:0]   sync_char,
    input  logic           irq_en,
    input  logic           rd_strobe,
    output logic [W-1:0]   rx_char,
    output logic           data_ready,
    output logic           overrun,
    output logic           rx_active,
    output logic           sync_det,
    output logic           rx_irq
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] len, shamt, last_idx;
    logic [W:0]    mask_w;
    logic [W-1:0]  win_nxt, window, sync_m;
    logic          match, deliver, sync_seen;

    always_comb begin
        len      = CW'(MIN_LEN) + CW'(len_sel);
        shamt    = CW'(W) - len;
        last_idx = len - 1'b1;
        mask_w   = ((W+1)'(1) << len) - 1'b1;
        sync_m   = sync_char & mask_w[W-1:0];
        window   = win_nxt >> shamt;
        match    = (window == sync_m);
        rx_irq   = data_ready && irq_en;
    end

    sync_rx_shift #(.W(W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(!rx_enable), .bit_en(bit_en),
        .line_in(line_rx), .loop_in(loop_tx), .loop_sel(loop_sel),
        .win_nxt(win_nxt)
    );

    sync_rx_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .bit_en(bit_en),
        .match(match), .strip(strip_sync), .last_idx(last_idx),
        .deliver(deliver), .sync_seen(sync_seen), .rx_active(rx_active)
    );

    sync_rx_hold #(.W(W)) u_hold (
        .clk(clk), .rst_n(rst_n), .deliver(deliver), .sync_seen(sync_seen),
        .rd(rd_strobe), .new_char(window), .rx_char(rx_char),
        .data_ready(data_ready), .overrun(overrun), .sync_det(sync_det)
    );

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |=> ((rx_char >> len) == '0)); // R1
endmodule

// File: tb/sim_sync_char_rx.sv
module sim_sync_char_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, line_rx = 1'b0, loop_tx = 1'b0, loop_sel = 1'b0;
    logic       rx_enable = 1'b0, strip_sync = 1'b0, irq_en = 1'b0, rd_strobe = 1'b0;
    logic [1:0] len_sel = 2'd0;
    logic [7:0] sync_char = 8'h00;
    logic [7:0] rx_char;
    logic       data_ready, overrun, rx_active, sync_det, rx_irq;

    always #10 clk = ~clk;

    sync_char_rx u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .line_rx(line_rx),
        .loop_tx(loop_tx), .loop_sel(loop_sel), .rx_enable(rx_enable),
        .strip_sync(strip_sync), .len_sel(len_sel), .sync_char(sync_char),
        .irq_en(irq_en), .rd_strobe(rd_strobe), .rx_char(rx_char),
        .data_ready(data_ready), .overrun(overrun), .rx_active(rx_active),
        .sync_det(sync_det), .rx_irq(rx_irq)
    );

    int total = 0, bad = 0;
    int m_len = 5, m_syncm = 0, m_strip = 0;
    int m_en = 0, m_state = 0, m_cnt = 0, m_win = 0;
    int m_ready = 0, m_char = 0, m_ovr = 0, m_act = 0, m_sdet = 0;
    int unsigned seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(int'(data_ready) == m_ready, "R7 data_ready", int'(data_ready), m_ready);
        chk(int'(overrun) == m_ovr, "R8 overrun", int'(overrun), m_ovr);
        chk(int'(rx_active) == m_act, "R6 rx_active", int'(rx_active), m_act);
        chk(int'(sync_det) == m_sdet, "R4 sync_det", int'(sync_det), m_sdet);
        chk(int'(rx_irq) == (m_ready & int'(irq_en)), "R9 rx_irq", int'(rx_irq), m_ready & int'(irq_en));
        chk(int'(rx_char) == m_char, "R1 R2 R5 rx_char", int'(rx_char), m_char);
    endtask

    task automatic model_bit(input int b);
        if (m_en == 0) return;
        m_win = (m_win >> 1) | (b << (m_len - 1));
        if (m_state == 1) begin
            if (m_win == m_syncm) begin
                m_sdet = 1; m_state = 2; m_cnt = 0;
            end
        end else if (m_state == 2) begin
            m_cnt++;
            if (m_cnt == m_len) begin
                m_cnt = 0;
                if (m_win == m_syncm) m_sdet = 1;
                if (!(m_strip == 1 && m_win == m_syncm)) begin
                    if (m_ready == 1) m_ovr = 1;
                    m_char = m_win; m_ready = 1; m_act = 1;
                end
            end
        end
    endtask

    // R10: the unselected input carries the complement; R12: input flips between strobes
    task automatic send_bit(input int b);
        @(negedge clk);
        if (loop_sel) begin loop_tx = b[0]; line_rx = ~b[0]; end
        else          begin line_rx = b[0]; loop_tx = ~b[0]; end
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        line_rx = ~line_rx;
        loop_tx = ~loop_tx;
        model_bit(b);
        compare_all();
    endtask

    task automatic send_char(input int v);
        for (int i = 0; i < m_len; i++) send_bit((v >> i) & 1);
    endtask

    task automatic do_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        m_ready = 0; m_ovr = 0; m_sdet = 0;
        compare_all();
    endtask

    task automatic set_enable(input bit e);
        @(negedge clk); rx_enable = e;
        @(negedge clk);
        if (e) begin m_en = 1; m_state = 1; end
        else begin m_en = 0; m_state = 0; m_act = 0; m_win = 0; m_cnt = 0; end
        compare_all();
    endtask

    initial begin
        #(20 * 200000);
        total++; bad++;
        $display("FAIL watchdog R7 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int syncs [3];
        syncs[0] = 8'h16; syncs[1] = 8'hA7; syncs[2] = 8'h3C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all(); // reset state, R7 R6 R4 R8
        chk(rx_char == 8'h00, "R7 reset rx_char", int'(rx_char), 0);
        for (int ls = 0; ls < 4; ls++) begin
            for (int si = 0; si < 3; si++) begin
                for (int st = 0; st < 2; st++) begin
                    set_enable(1'b0);
                    len_sel    = 2'(ls);
                    sync_char  = 8'(syncs[si]);
                    strip_sync = st[0];
                    loop_sel   = (si == 1);
                    irq_en     = st[0] ^ ls[0];
                    m_len      = ls + 5;
                    m_syncm    = syncs[si] & ((1 << m_len) - 1);
                    m_strip    = st;
                    set_enable(1'b1);
                    // R3: noise preamble, any false lock is tracked by the model
                    for (int p = 0; p < 12; p++) begin
                        seed = seed * 1103515245 + 12345;
                        send_bit(int'((seed >> 16) & 1));
                    end
                    if (m_ready == 1) do_read();
                    send_char(m_syncm);
                    send_char(m_syncm); // R5 second sync: stripped or delivered
                    if (m_ready == 1) do_read();
                    for (int k = 0; k < 4; k++) begin
                        send_char((ls * 29 + si * 71 + st * 13 + k * 47 + 5) & 255);
                        if (k != 1 && m_ready == 1) do_read(); // k==1 left unread: R8
                    end
                    // R11: disabled receiver ignores sync and data
                    set_enable(1'b0);
                    send_char(m_syncm);
                    send_char(8'h5A);
                    chk(rx_active == 1'b0, "R11 rx_active off", int'(rx_active), 0);
                end
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule